// File: doc/BRIEF.md
# Dual-Queue Conversion Scheduler

This block decides which of two command queues drives a single shared converter, and keeps a six-bit status field that reports the state of both queues. Queue one always wins. A trigger for queue one takes the converter away from a running queue two and aborts its conversion. Queue two is parked until queue one goes idle or pauses, and then resumes from the same command.

A queue advances its command pointer each time a conversion finishes. It stops at a command that has its pause bit set, and waits there for its next trigger. It returns to its base pointer at a command that has its end flag set. If queue two is triggered while queue one owns the converter, queue two is marked as trigger pending. Once queue one releases the converter, queue two stays pending for a fixed number of cycles before it starts.

Stop mode clears everything to idle. Debug freeze holds the whole state, including a queue shown as active. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `dqs_top`

## Requirements
- R1: After reset, the status field reads 0. Both pointers sit at their bases (queue one at 0, queue two at 32). Start and abort are low.
- R2: Status is {q1 code in bits 5:3, q2 code in bits 2:0}. The q1 codes are idle 0, active 1, paused 2. The q2 codes are idle 0, active 1, paused 2, suspended 3, pending 4. A queue one trigger while queue one is idle or paused makes it active. The cycle after the trigger edge, start is high and `q2_sel` is low.
- R3: A done strobe whose pause and end bits are both clear advances the active queue's pointer by one. It issues a new start for the same queue.
- R4: A done strobe with the pause bit set advances the pointer, marks the queue paused and issues no start for it. The next trigger on that queue resumes it from the advanced pointer.
- R5: A done strobe with the end bit set returns the queue to idle and its pointer to its base.
- R6: A queue one trigger while queue two is active pulses abort and start together. The status then reads q1 active, q2 suspended. Queue two's pointer does not change.
- R7: When queue one pauses or ends while queue two is suspended, queue two becomes active in the next cycle. A start is issued and its pointer is unchanged.
- R8: A queue two trigger while queue one is active, or in the same cycle as a queue one trigger, sets q2 to pending.
- R9: When queue one leaves active with q2 pending, q2 reads pending for exactly 2 more cycles, then reads active with a start pulse. A queue one trigger inside that window makes queue one active, and q2 stays pending.
- R10: A queue two trigger while queue one is paused makes queue two active at once.
- R11: While freeze is high, the status and pointers hold. No start or abort is issued, and triggers and done strobes are ignored.
- R12: Stop mode forces both queues idle and both pointers to their bases in the next cycle. It takes priority over freeze.
- R13: At most one queue is active. A trigger to a queue that is already active or suspended has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q1_trig | input | 1 | Queue one trigger event |
| q2_trig | input | 1 | Queue two trigger event |
| conv_done | input | 1 | Current conversion finished |
| cmd_pause | input | 1 | Pause bit of the finished command |
| cmd_last | input | 1 | End-of-queue bit of the finished command |
| stop_mode | input | 1 | Stop mode, clears all state |
| freeze | input | 1 | Debug freeze, holds all state |
| q2_sel | output | 1 | High when queue two owns the converter |
| start_conv | output | 1 | Start a conversion for the selected queue |
| abort_conv | output | 1 | Abort the conversion in progress |
| q1_ptr | output | 6 | Queue one command pointer |
| q2_ptr | output | 6 | Queue two command pointer |
| status | output | 6 | Combined queue status field |

## Verification
The hardest state to reach from the ports is the pending window: queue one must have been active, queue two triggered during that time, and queue one must then end or pause. A queue one trigger landing inside those two cycles is harder still. The stimulus table walks through exactly that chain of events. It counts cycles after the release to confirm the two pending cycles and the start that follows. A later row drops a queue one trigger into the window. Preemption of a queue two command that is already advancing, followed by a resume through queue one pausing, is also built up row by row.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    Q1_IDLE  = 3'd0,
    Q1_ACT   = 3'd1,
    Q1_PAUSE = 3'd2
  } q1_st_e;

  typedef enum logic [ST_W-1:0] {
    Q2_IDLE  = 3'd0,
    Q2_ACT   = 3'd1,
    Q2_PAUSE = 3'd2,
    Q2_SUSP  = 3'd3,
    Q2_PEND  = 3'd4
  } q2_st_e;
endpackage

// File: rtl/dqs_ptr.sv
module dqs_ptr #(
  parameter int PTR_W = 6,
  parameter logic [PTR_W-1:0] BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             rewind,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= BASE;
    else if (rewind) ptr <= BASE;
    else if (adv)    ptr <= ptr + PTR_W'(1);
  end
endmodule

// File: rtl/dqs_ctrl.sv
module dqs_ctrl
  import dqs_pkg::*;
#(
  parameter int PEND_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   q1_trig,
  input  logic   q2_trig,
  input  logic   conv_done,
  input  logic   cmd_pause,
  input  logic   cmd_last,
  input  logic   stop_mode,
  input  logic   freeze,
  output q1_st_e q1_st,
  output q2_st_e q2_st,
  output logic   start_conv,
  output logic   abort_conv,
  output logic   adv1,
  output logic   rew1,
  output logic   adv2,
  output logic   rew2
);
  localparam int CW = $clog2(PEND_CYC + 1);

  q1_st_e       n1;
  q2_st_e       n2;
  logic [CW-1:0] cnt, ncnt;
  logic          st, ab, q1_leave;

  always_comb begin
    n1 = q1_st; n2 = q2_st; ncnt = cnt;
    st = 1'b0; ab = 1'b0; q1_leave = 1'b0;
    adv1 = 1'b0; rew1 = 1'b0; adv2 = 1'b0; rew2 = 1'b0;
    if (stop_mode) begin
      n1 = Q1_IDLE; n2 = Q2_IDLE; ncnt = '0;
      rew1 = 1'b1; rew2 = 1'b1;
    end else if (!freeze) begin
      // completion of the running command
      if (conv_done && q1_st == Q1_ACT) begin
        if (cmd_last) begin
          n1 = Q1_IDLE; rew1 = 1'b1; q1_leave = 1'b1;
        end else begin
          adv1 = 1'b1;
          if (cmd_pause) begin n1 = Q1_PAUSE; q1_leave = 1'b1; end
          else st = 1'b1;
        end
      end else if (conv_done && q2_st == Q2_ACT) begin
        if (cmd_last) begin
          n2 = Q2_IDLE; rew2 = 1'b1;
        end else begin
          adv2 = 1'b1;
          if (cmd_pause) n2 = Q2_PAUSE;
          else st = 1'b1;
        end
      end
      // transient pending window countdown
      if (cnt != '0) begin
        if (cnt == CW'(1)) begin
          n2 = Q2_ACT; st = 1'b1; ncnt = '0;
        end else begin
          ncnt = cnt - CW'(1);
        end
      end
      // queue one releases the converter
      if (q1_leave) begin
        if (q2_st == Q2_SUSP) begin
          n2 = Q2_ACT; st = 1'b1;
        end else if (q2_st == Q2_PEND) begin
          ncnt = CW'(PEND_CYC);
        end
      end
      // queue two trigger
      if (q2_trig && (n2 == Q2_IDLE || n2 == Q2_PAUSE)) begin
        if (n1 == Q1_ACT || (q1_trig && q1_st != Q1_ACT)) n2 = Q2_PEND;
        else begin n2 = Q2_ACT; st = 1'b1; end
      end
      // queue one trigger preempts
      if (q1_trig && q1_st != Q1_ACT) begin
        n1 = Q1_ACT; st = 1'b1; ncnt = '0;
        if (n2 == Q2_ACT) begin
          n2 = Q2_SUSP;
          ab = (q2_st == Q2_ACT) && !conv_done;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1_st <= Q1_IDLE; q2_st <= Q2_IDLE; cnt <= '0;
      start_conv <= 1'b0; abort_conv <= 1'b0;
    end else begin
      q1_st <= n1; q2_st <= n2; cnt <= ncnt;
      start_conv <= st; abort_conv <= ab;
    end
  end

  p_one_active_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_st == Q1_ACT && q2_st == Q2_ACT));

  p_abort_suspends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_conv |-> (q1_st == Q1_ACT && q2_st == Q2_SUSP && start_conv));

  p_susp_under_q1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q2_st == Q2_SUSP) |-> (q1_st == Q1_ACT));

  p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !stop_mode) |=> ($stable(q1_st) && $stable(q2_st) && !start_conv && !abort_conv));

  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (q1_st == Q1_IDLE && q2_st == Q2_IDLE && !start_conv));
endmodule

// File: rtl/dqs_top.sv
module dqs_top
  import dqs_pkg::*;
#(
  parameter int PTR_W    = 6,
  parameter int Q1_BASE  = 0,
  parameter int Q2_BASE  = 32,
  parameter int PEND_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q1_trig,
  input  logic             q2_trig,
  input  logic             conv_done,
  input  logic             cmd_pause,
  input  logic             cmd_last,
  input  logic             stop_mode,
  input  logic             freeze,
  output logic             q2_sel,
  output logic             start_conv,
  output logic             abort_conv,
  output logic [PTR_W-1:0] q1_ptr,
  output logic [PTR_W-1:0] q2_ptr,
  output logic [2*ST_W-1:0] status
);
  q1_st_e q1_st;
  q2_st_e q2_st;
  logic [1:0] adv, rew;
  logic [PTR_W-1:0] ptrs [2];

  dqs_ctrl #(.PEND_CYC(PEND_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .q1_trig(q1_trig), .q2_trig(q2_trig),
    .conv_done(conv_done), .cmd_pause(cmd_pause), .cmd_last(cmd_last),
    .stop_mode(stop_mode), .freeze(freeze), .q1_st(q1_st), .q2_st(q2_st),
    .start_conv(start_conv), .abort_conv(abort_conv),
    .adv1(adv[0]), .rew1(rew[0]), .adv2(adv[1]), .rew2(rew[1])
  );

  for (genvar q = 0; q < 2; q++) begin : g_ptr
    localparam logic [PTR_W-1:0] BASE_Q = PTR_W'((q == 0) ? Q1_BASE : Q2_BASE);
    dqs_ptr #(.PTR_W(PTR_W), .BASE(BASE_Q)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(adv[q]), .rewind(rew[q]), .ptr(ptrs[q])
    );
  end

  assign q1_ptr = ptrs[0];
  assign q2_ptr = ptrs[1];
  assign q2_sel = (q2_st == Q2_ACT);
  assign status = {q1_st, q2_st};
endmodule

// File: tb/dqs_top_test.sv
module dqs_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic q1_trig = 0, q2_trig = 0, conv_done = 0, cmd_pause = 0, cmd_last = 0;
  logic stop_mode = 0, freeze = 0;
  logic q2_sel, start_conv, abort_conv;
  logic [5:0] q1_ptr, q2_ptr, status;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_top uut (
    .clk(clk), .rst_n(rst_n), .q1_trig(q1_trig), .q2_trig(q2_trig),
    .conv_done(conv_done), .cmd_pause(cmd_pause), .cmd_last(cmd_last),
    .stop_mode(stop_mode), .freeze(freeze), .q2_sel(q2_sel),
    .start_conv(start_conv), .abort_conv(abort_conv),
    .q1_ptr(q1_ptr), .q2_ptr(q2_ptr), .status(status)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic t1, t2, dn, pa, la, st, fr;
    logic [2:0] e1, e2;
    logic es, ea;
    logic [5:0] p1, p2;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1,0,0,0,0,0,0, 3'd1,3'd0, 1,0, 6'd0, 6'd32}, // R2 q1 starts
    '{4'd3,  0,0,1,0,0,0,0, 3'd1,3'd0, 1,0, 6'd1, 6'd32}, // R3 advance
    '{4'd8,  0,1,0,0,0,0,0, 3'd1,3'd4, 0,0, 6'd1, 6'd32}, // R8 pending
    '{4'd8,  0,0,0,0,0,0,0, 3'd1,3'd4, 0,0, 6'd1, 6'd32},
    '{4'd5,  0,0,1,0,1,0,0, 3'd0,3'd4, 0,0, 6'd0, 6'd32}, // R5 end, R9 window 1
    '{4'd9,  0,0,0,0,0,0,0, 3'd0,3'd4, 0,0, 6'd0, 6'd32}, // R9 window 2
    '{4'd9,  0,0,0,0,0,0,0, 3'd0,3'd1, 1,0, 6'd0, 6'd32}, // R9 q2 starts
    '{4'd3,  0,0,1,0,0,0,0, 3'd0,3'd1, 1,0, 6'd0, 6'd33}, // R3 q2 advance
    '{4'd6,  1,0,0,0,0,0,0, 3'd1,3'd3, 1,1, 6'd0, 6'd33}, // R6 preempt
    '{4'd13, 0,1,0,0,0,0,0, 3'd1,3'd3, 0,0, 6'd0, 6'd33}, // R13 trig on suspended
    '{4'd7,  0,0,1,1,0,0,0, 3'd2,3'd1, 1,0, 6'd1, 6'd33}, // R4 R7 pause, resume
    '{4'd5,  0,0,1,0,1,0,0, 3'd2,3'd0, 0,0, 6'd1, 6'd32}, // R5 q2 end
    '{4'd10, 0,1,0,0,0,0,0, 3'd2,3'd1, 1,0, 6'd1, 6'd32}, // R10
    '{4'd4,  0,0,1,1,0,0,0, 3'd2,3'd2, 0,0, 6'd1, 6'd33}, // R4 both paused
    '{4'd4,  1,0,0,0,0,0,0, 3'd1,3'd2, 1,0, 6'd1, 6'd33}, // R4 resume q1
    '{4'd13, 1,0,0,0,0,0,0, 3'd1,3'd2, 0,0, 6'd1, 6'd33}, // R13 trig on active
    '{4'd11, 0,1,1,0,1,0,1, 3'd1,3'd2, 0,0, 6'd1, 6'd33}, // R11 freeze
    '{4'd5,  0,0,1,0,1,0,0, 3'd0,3'd2, 0,0, 6'd0, 6'd33}, // R5
    '{4'd10, 0,1,0,0,0,0,0, 3'd0,3'd1, 1,0, 6'd0, 6'd33}, // R10 from idle q1
    '{4'd12, 1,0,0,0,0,1,0, 3'd0,3'd0, 0,0, 6'd0, 6'd32}, // R12 stop
    '{4'd8,  1,1,0,0,0,0,0, 3'd1,3'd4, 1,0, 6'd0, 6'd32}, // R8 simultaneous
    '{4'd9,  0,0,1,0,1,0,0, 3'd0,3'd4, 0,0, 6'd0, 6'd32}, // R9 window opens
    '{4'd9,  1,0,0,0,0,0,0, 3'd1,3'd4, 1,0, 6'd0, 6'd32}, // R9 q1 in window
    '{4'd9,  0,0,1,1,0,0,0, 3'd2,3'd4, 0,0, 6'd1, 6'd32}, // R9 reopen
    '{4'd9,  0,0,0,0,0,0,0, 3'd2,3'd4, 0,0, 6'd1, 6'd32},
    '{4'd9,  0,0,0,0,0,0,0, 3'd2,3'd1, 1,0, 6'd1, 6'd32}  // R9 q2 starts
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic t1, t2, dn, pa, la, st, fr);
    q1_trig = t1; q2_trig = t2; conv_done = dn; cmd_pause = pa;
    cmd_last = la; stop_mode = st; freeze = fr;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "WDOG", "timeout", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 6'd0 && q1_ptr == 6'd0 && q2_ptr == 6'd32 && !start_conv && !abort_conv,
        "R1", "reset status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 6'd0 && !start_conv, "R1", "idle after reset", status, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].t1, VECS[i].t2, VECS[i].dn, VECS[i].pa, VECS[i].la,
            VECS[i].st, VECS[i].fr);
      @(posedge clk);
      #1;
      begin
        string r;
        r = $sformatf("R%0d", VECS[i].rq);
        chk(status == {VECS[i].e1, VECS[i].e2}, r, $sformatf("status row %0d", i),
            status, {VECS[i].e1, VECS[i].e2});
        chk(start_conv == VECS[i].es, r, $sformatf("start row %0d", i), start_conv, VECS[i].es);
        chk(abort_conv == VECS[i].ea, r, $sformatf("abort row %0d", i), abort_conv, VECS[i].ea);
        chk(q1_ptr == VECS[i].p1, r, $sformatf("q1_ptr row %0d", i), q1_ptr, VECS[i].p1);
        chk(q2_ptr == VECS[i].p2, r, $sformatf("q2_ptr row %0d", i), q2_ptr, VECS[i].p2);
        chk(q2_sel == (VECS[i].e2 == 3'd1), "R2", $sformatf("q2_sel row %0d", i),
            q2_sel, VECS[i].e2 == 3'd1);
      end
    end

    // R6: preempt again, then R11 freeze held over several cycles
    @(negedge clk); drive(1,0,0,0,0,0,0);
    @(negedge clk);
    chk(status == 6'o13 && abort_conv, "R6", "preempt q2", status, 6'o13);
    drive(0,0,1,0,1,0,1);
    repeat (3) @(negedge clk);
    chk(status == 6'o13 && !start_conv && q1_ptr == 6'd1, "R11", "freeze hold", status, 6'o13);
    // R12 stop overrides freeze
    drive(0,0,0,0,0,1,1);
    @(negedge clk);
    chk(status == 6'd0 && q1_ptr == 6'd0 && q2_ptr == 6'd32, "R12", "stop over freeze",
        status, 0);
    drive(0,0,0,0,0,0,0);
    @(negedge clk);
    chk(status == 6'd0 && !start_conv, "R12", "stays idle", status, 0);
    summary();
  end
endmodule